// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Decoder Model

This block is a clock-sampled behavioural responder for a 16-bit wide dynamic RAM with two column strobes, one for each byte lane. A testbench drives the row strobe, the two column strobes, the write and output enables, a 9-bit multiplexed address and a 16-bit write word. On every clock the block compares these samples with the ones from the previous clock. From the order of the strobe edges it works out which kind of cycle the memory controller is running, and reports it.

It supports single and page-mode reads and writes within one open row. Writes can be early, late or read-modify-write. Refresh can be by address alone, with a column strobe held low ahead of the row strobe, or hidden behind a held read. Read data stays on the lanes after a column strobe rises, in extended-data-out fashion. Each lane's output enable follows its own column strobe. An internal row counter feeds strobe-first refreshes. A per-row age tracker raises a flag when any row has gone longer than a set number of clocks without a refresh. The data store covers a small window of the address space: the low 3 row bits and the low 3 column bits pick one of 64 words.

Top module: `edo_dram_cycle_model`

## Requirements
- R1: After reset both lane drive outputs are 0, `cyc_kind` is 0, `rf_stb` is 0, `stale` is 0, and the refresh counter holds 0.
- R2: A row-strobe fall with both column strobes high reports `cyc_kind`=1 and pulses `rf_stb` with `rf_row` equal to the address. A row-strobe rise that ends such a period with no column access reports `cyc_kind`=2. All results appear one clock after the sampled inputs.
- R3: A row-strobe fall with either column strobe low, while no lane holds read data, is a counter refresh: `cyc_kind`=3, `rf_row` is the counter value, the address is ignored and both lanes stay off. Either strobe alone is enough. The counter then steps by one and wraps from 511 to 0.
- R4: The first column-strobe fall in an open row with write enable high is a read (`cyc_kind`=5). `dout` gives the stored word. Lane 7:0 drives only if the lower strobe is low, and lane 15:8 only if the upper strobe is low.
- R5: Write enable low at the column-strobe fall is an early write (`cyc_kind`=6). It stores only the lanes whose strobe is low, and both lanes stay off.
- R6: Write enable falling while a read access still has a column strobe low is a late write (`cyc_kind`=7) if output enable was never sampled low since that column fall. Otherwise it is a read-modify-write (`cyc_kind`=8). Either kind writes the lanes whose strobe is low at that sample.
- R7: `page_acc` is 0 for the first column access after a row-strobe fall and 1 for every later one in the same row period. Each later access uses its own column address.
- R8: After the column strobes rise with the row strobe still low, read data stays driven until the next column fall. Both lanes turn off once the row strobe and both column strobes are sampled high.
- R9: A lane drives only while output enable is sampled low and write enable high. Raising output enable during a read turns the lanes off, and lowering it again turns them back on.
- R10: Pulsing the row strobe high and then low while a column strobe stays low and read data is held is a hidden refresh (`cyc_kind`=4). It refreshes the counter row, steps the counter, and keeps the same data driven throughout.
- R11: `stale` rises when any row has gone `REFRESH_LIMIT` clocks without a refresh, and falls once every row has been refreshed within that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Column strobe for bits 7:0, active low |
| ucas_n | input | 1 | Column strobe for bits 15:8, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data held for the lanes |
| drv_lo | output | 1 | Drive enable for bits 7:0 |
| drv_hi | output | 1 | Drive enable for bits 15:8 |
| cyc_kind | output | 4 | Event code: 0 none, 1 row open, 2 address-only refresh, 3 counter refresh, 4 hidden refresh, 5 read, 6 early write, 7 late write, 8 read-modify-write |
| page_acc | output | 1 | Last column access was not the first in its row period |
| rf_stb | output | 1 | A row was refreshed on this event |
| rf_row | output | ROW_W | Row refreshed |
| stale | output | 1 | Some row exceeded the refresh age limit |

## Verification
The assertions assume every strobe level is held for at least one clock, so each edge shows up as a change between two consecutive samples. They also assume the data-driving state starts empty after reset. The bench changes inputs only on the falling clock edge and steps the strobes one level change at a time. It never takes a strobe low and high again within one sample, so the ordering the checks rely on (column before row for counter refresh, write enable before or after the column fall) is always visible to the decoder.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [3:0] {
        EV_NONE     = 4'd0,
        EV_ROW_OPEN = 4'd1,
        EV_RAS_ONLY = 4'd2,
        EV_CBR      = 4'd3,
        EV_HIDDEN   = 4'd4,
        EV_READ     = 4'd5,
        EV_EARLY_WR = 4'd6,
        EV_LATE_WR  = 4'd7,
        EV_RMW      = 4'd8
    } cyc_ev_e;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_OPEN = 2'd1,
        M_RFSH = 2'd2
    } ras_mode_e;

endpackage

// File: rtl/dcm_refresh_ctr.sv
module dcm_refresh_ctr #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] cnt
);
    logic [ROW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv) cnt_d = cnt_q + 1'b1;   // natural wrap at all-ones
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dcm_store.sv
module dcm_store #(
    parameter int AW     = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_lane,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH  = 1 << AW;
    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] wmask;

    // one mask slice per byte lane
    for (genvar l = 0; l < 2; l++) begin : g_lane
        assign wmask[l*LANE_W +: LANE_W] = {LANE_W{wr_lane[l]}};
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (wr_en)
            mem_d[wr_addr] = (mem_q[wr_addr] & ~wmask) | (wr_data & wmask);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/dcm_age_tracker.sv
module dcm_age_tracker #(
    parameter int ROW_W = 9,
    parameter int LIMIT = 16384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [ROW_W-1:0] hit_row,
    output logic             stale
);
    localparam int ROWS  = 1 << ROW_W;
    localparam int AGE_W = $clog2(LIMIT + 1);
    localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(LIMIT);

    logic [AGE_W-1:0] age_q [ROWS];
    logic [AGE_W-1:0] age_d [ROWS];
    logic [ROWS-1:0]  at_top;
    logic             stale_d, stale_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign at_top[r] = (age_q[r] == AGE_TOP);
        assign age_d[r]  = (hit && hit_row == ROW_W'(r)) ? '0 :
                           at_top[r] ? age_q[r] : age_q[r] + 1'b1;
    end

    assign stale_d = |at_top;

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROWS; i++) begin
            if (!rst_n) age_q[i] <= '0;
            else        age_q[i] <= age_d[i];
        end
        if (!rst_n) stale_q <= 1'b0;
        else        stale_q <= stale_d;
    end

    assign stale = stale_q;
endmodule

// File: rtl/edo_dram_cycle_model.sv
module edo_dram_cycle_model
    import dcm_pkg::*;
#(
    parameter int ROW_W         = 9,
    parameter int COL_W         = 8,
    parameter int DATA_W        = 16,
    parameter int MEM_ROW_BITS  = 3,
    parameter int MEM_COL_BITS  = 3,
    parameter int REFRESH_LIMIT = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ROW_W-1:0]  addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              drv_lo,
    output logic              drv_hi,
    output logic [3:0]        cyc_kind,
    output logic              page_acc,
    output logic              rf_stb,
    output logic [ROW_W-1:0]  rf_row,
    output logic              stale
);
    localparam int MEM_AW = MEM_ROW_BITS + MEM_COL_BITS;

    typedef struct packed {
        logic              ras_p;
        logic              lcas_p;
        logic              ucas_p;
        logic              we_p;
        ras_mode_e         mode;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              acc_on;
        logic              acc_wr;
        logic              acc_shown;
        logic              touched;
        logic [1:0]        lane_ok;
        logic [DATA_W-1:0] dout;
        logic [1:0]        drive;
        cyc_ev_e           ev;
        logic              page;
        logic              rf_stb;
        logic [ROW_W-1:0]  rf_row;
    } state_t;

    state_t st_d, st_q;

    logic              cas_now, cas_prev;
    logic              ras_fall, ras_rise, cas_fall, we_fall;
    logic [1:0]        lanes_now;
    logic              wr_en;
    logic [1:0]        wr_lane;
    logic [MEM_AW-1:0] idx_now, idx_held, wr_idx;
    logic [DATA_W-1:0] rd_word;
    logic              cnt_adv;
    logic [ROW_W-1:0]  cnt;

    assign cas_now   = !lcas_n || !ucas_n;
    assign cas_prev  = !st_q.lcas_p || !st_q.ucas_p;
    assign ras_fall  = st_q.ras_p && !ras_n;
    assign ras_rise  = !st_q.ras_p && ras_n;
    assign cas_fall  = cas_now && !cas_prev;
    assign we_fall   = st_q.we_p && !we_n;
    assign lanes_now = {!ucas_n, !lcas_n};
    assign idx_now   = {st_q.row[MEM_ROW_BITS-1:0], addr[MEM_COL_BITS-1:0]};
    assign idx_held  = {st_q.row[MEM_ROW_BITS-1:0], st_q.col[MEM_COL_BITS-1:0]};

    always_comb begin
        st_d        = st_q;
        st_d.ras_p  = ras_n;
        st_d.lcas_p = lcas_n;
        st_d.ucas_p = ucas_n;
        st_d.we_p   = we_n;
        st_d.ev     = EV_NONE;
        st_d.rf_stb = 1'b0;
        wr_en       = 1'b0;
        wr_lane     = 2'b00;
        wr_idx      = idx_held;
        cnt_adv     = 1'b0;

        if (ras_fall) begin
            st_d.acc_on  = 1'b0;
            st_d.touched = 1'b0;
            st_d.page    = 1'b0;
            st_d.rf_stb  = 1'b0;
            if (cas_now) begin
                // column strobe already low: refresh from the internal counter
                st_d.mode   = M_RFSH;
                st_d.rf_stb = 1'b1;
                st_d.rf_row = cnt;
                cnt_adv     = 1'b1;
                if (|st_q.lane_ok) begin
                    st_d.ev = EV_HIDDEN;
                end else begin
                    st_d.ev      = EV_CBR;
                    st_d.lane_ok = 2'b00;
                end
            end else begin
                st_d.mode   = M_OPEN;
                st_d.row    = addr;
                st_d.rf_stb = 1'b1;
                st_d.rf_row = addr;
                st_d.ev     = EV_ROW_OPEN;
            end
        end else if (ras_rise) begin
            if (st_q.mode == M_OPEN && !st_q.touched) st_d.ev = EV_RAS_ONLY;
            st_d.mode   = M_IDLE;
            st_d.acc_on = 1'b0;
        end else if (st_q.mode == M_OPEN && !ras_n) begin
            if (cas_fall) begin
                st_d.col     = addr[COL_W-1:0];
                st_d.touched = 1'b1;
                st_d.page    = st_q.touched;
                st_d.acc_on  = 1'b1;
                if (!we_n) begin
                    st_d.ev      = EV_EARLY_WR;
                    wr_en        = 1'b1;
                    wr_lane      = lanes_now;
                    wr_idx       = idx_now;
                    st_d.acc_wr  = 1'b1;
                    st_d.lane_ok = 2'b00;
                end else begin
                    st_d.ev        = EV_READ;
                    st_d.dout      = rd_word;
                    st_d.lane_ok   = lanes_now;
                    st_d.acc_wr    = 1'b0;
                    st_d.acc_shown = !oe_n;
                end
            end else if (st_q.acc_on && cas_now && !st_q.acc_wr) begin
                if (we_fall) begin
                    st_d.ev      = (st_q.acc_shown || !oe_n) ? EV_RMW : EV_LATE_WR;
                    wr_en        = 1'b1;
                    wr_lane      = lanes_now;
                    st_d.acc_wr  = 1'b1;
                    st_d.lane_ok = 2'b00;
                end else if (!oe_n) begin
                    st_d.acc_shown = 1'b1;
                end
            end else if (!cas_now) begin
                st_d.acc_on = 1'b0;
            end
        end

        // all strobes high: lanes go to high impedance
        if (ras_n && !cas_now) st_d.lane_ok = 2'b00;

        st_d.drive = st_d.lane_ok & {2{!oe_n && we_n}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ras_p     <= 1'b1;
            st_q.lcas_p    <= 1'b1;
            st_q.ucas_p    <= 1'b1;
            st_q.we_p      <= 1'b1;
            st_q.mode      <= M_IDLE;
            st_q.ev        <= EV_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    dcm_store #(
        .AW     (MEM_AW),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_lane (wr_lane),
        .wr_addr (wr_idx),
        .wr_data (din),
        .rd_addr (idx_now),
        .rd_data (rd_word)
    );

    dcm_refresh_ctr #(
        .ROW_W (ROW_W)
    ) u_rctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (cnt_adv),
        .cnt   (cnt)
    );

    dcm_age_tracker #(
        .ROW_W (ROW_W),
        .LIMIT (REFRESH_LIMIT)
    ) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (st_d.rf_stb),
        .hit_row (st_d.rf_row),
        .stale   (stale)
    );

    assign dout     = st_q.dout;
    assign drv_lo   = st_q.drive[0];
    assign drv_hi   = st_q.drive[1];
    assign cyc_kind = st_q.ev;
    assign page_acc = st_q.page;
    assign rf_stb   = st_q.rf_stb;
    assign rf_row   = st_q.rf_row;
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker #(
    parameter int ROW_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             lcas_n,
    input logic             ucas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [ROW_W-1:0] addr,
    input logic             drv_lo,
    input logic             drv_hi,
    input logic [3:0]       cyc_kind,
    input logic             rf_stb,
    input logic [ROW_W-1:0] rf_row
);
    p_open_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 4'd1) |-> (rf_stb && rf_row == $past(addr)));

    p_ras_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 4'd2) |-> $past(ras_n));

    p_cbr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 4'd3) |-> (!drv_lo && !drv_hi));

    p_counter_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 4'd3 || cyc_kind == 4'd4) |-> (rf_stb && !$past(ras_n)));

    p_early_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 4'd6) |-> (!drv_lo && !drv_hi));

    p_all_high_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ras_n) && $past(lcas_n) && $past(ucas_n)) |-> (!drv_lo && !drv_hi));

    p_drive_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_lo || drv_hi) |-> (!$past(oe_n) && $past(we_n)));
endmodule

bind edo_dram_cycle_model dcm_checker #(.ROW_W(ROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .lcas_n   (lcas_n),
    .ucas_n   (ucas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .drv_lo   (drv_lo),
    .drv_hi   (drv_hi),
    .cyc_kind (cyc_kind),
    .rf_stb   (rf_stb),
    .rf_row   (rf_row)
);

// File: tb/sim_edo_dram_cycle_model.sv
`timescale 1ns/1ps
module sim_edo_dram_cycle_model;
    localparam int LIMIT = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        drv_lo, drv_hi, page_acc, rf_stb, stale;
    logic [3:0]  cyc_kind;
    logic [8:0]  rf_row;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [8:0] cnt = '0;

    typedef struct {
        bit ck_k;  logic [3:0]  k;   int rk;
        bit ck_d;  logic [1:0]  d;   int rd;
        bit ck_o;  logic [15:0] o;   int ro;
        bit ck_r;  logic [8:0]  r;   int rr;
        bit ck_p;  logic        p;   int rp;
        bit ck_s;  logic        s;   int rs;
    } exp_t;

    exp_t sb[$];
    exp_t ex;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    edo_dram_cycle_model #(.REFRESH_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
        .drv_lo(drv_lo), .drv_hi(drv_hi), .cyc_kind(cyc_kind), .page_acc(page_acc),
        .rf_stb(rf_stb), .rf_row(rf_row), .stale(stale)
    );

    task automatic chk(input int r, input string what, input logic [31:0] act, input logic [31:0] exv);
        checks++;
        if (act !== exv) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", r, what, act, exv);
        end
    endtask

    // monitor: pops one expectation per driven step, after the edge that consumed it
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                if (e.ck_k) chk(e.rk, "kind", 32'(cyc_kind), 32'(e.k));
                if (e.ck_d) chk(e.rd, "drive", 32'({drv_hi, drv_lo}), 32'(e.d));
                if (e.ck_o) chk(e.ro, "dout", 32'(dout), 32'(e.o));
                if (e.ck_r) begin
                    chk(e.rr, "rf_stb", 32'(rf_stb), 32'd1);
                    chk(e.rr, "rf_row", 32'(rf_row), 32'(e.r));
                end
                if (e.ck_p) chk(e.rp, "page", 32'(page_acc), 32'(e.p));
                if (e.ck_s) chk(e.rs, "stale", 32'(stale), 32'(e.s));
            end
        end
    end

    task automatic ek(input logic [3:0] k, input int r);  ex.ck_k = 1; ex.k = k; ex.rk = r; endtask
    task automatic ed(input logic [1:0] d, input int r);  ex.ck_d = 1; ex.d = d; ex.rd = r; endtask
    task automatic eo(input logic [15:0] o, input int r); ex.ck_o = 1; ex.o = o; ex.ro = r; endtask
    task automatic er(input logic [8:0] w, input int r);  ex.ck_r = 1; ex.r = w; ex.rr = r; endtask
    task automatic ep(input logic p, input int r);        ex.ck_p = 1; ex.p = p; ex.rp = r; endtask
    task automatic es(input logic s, input int r);        ex.ck_s = 1; ex.s = s; ex.rs = r; endtask

    // driver: apply one sample of inputs and queue what must follow it
    task automatic step(input logic r, input logic l, input logic u, input logic w,
                        input logic o, input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        ras_n = r; lcas_n = l; ucas_n = u; we_n = w; oe_n = o; addr = a; din = d;
        sb.push_back(ex);
        ex = '{default: 0};
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        ex = '{default: 0};
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        ek(4'd0, 1); ed(2'b00, 1); es(1'b0, 1);
        step(1,1,1,1,1, 9'd0, 16'h0);

        // R2 / R5: open row 5, early write full word at column 2
        ek(4'd1, 2); er(9'd5, 2);
        step(0,1,1,1,1, 9'd5, 16'h0);
        ek(4'd6, 5); ed(2'b00, 5); ep(1'b0, 7);
        step(0,0,0,0,1, 9'd2, 16'hA1B2);
        ed(2'b00, 5);
        step(0,1,1,1,1, 9'd2, 16'h0);
        ek(4'd0, 2);                       // accessed row: no address-only refresh
        step(1,1,1,1,1, 9'd0, 16'h0);

        // R5: lower-lane early write at column 3
        step(0,1,1,1,1, 9'd5, 16'h0);
        ek(4'd6, 5);
        step(0,0,1,0,1, 9'd3, 16'h1122);
        step(0,1,1,1,1, 9'd3, 16'h0);
        step(1,1,1,1,1, 9'd0, 16'h0);

        // R4 / R7 / R8 / R9: page-mode reads
        step(0,1,1,1,1, 9'd5, 16'h0);
        ek(4'd5, 4); eo(16'hA1B2, 4); ed(2'b11, 4); ep(1'b0, 7);
        step(0,0,0,1,0, 9'd2, 16'h0);
        ed(2'b11, 8); eo(16'hA1B2, 8);    // R8: held after column rise
        step(0,1,1,1,0, 9'd2, 16'h0);
        ek(4'd5, 7); ep(1'b1, 7); eo(16'h0022, 7); ed(2'b11, 7);
        step(0,0,0,1,0, 9'd3, 16'h0);
        ed(2'b00, 9);                      // R9: output enable high
        step(0,0,0,1,1, 9'd3, 16'h0);
        ed(2'b11, 9); eo(16'h0022, 9);     // R9: back on
        step(0,0,0,1,0, 9'd3, 16'h0);
        ed(2'b00, 8);                      // R8: all strobes high
        step(1,1,1,1,0, 9'd0, 16'h0);

        // R4: upper-lane-only read
        step(0,1,1,1,1, 9'd5, 16'h0);
        ek(4'd5, 4); ed(2'b10, 4); eo(16'hA1B2, 4);
        step(0,1,0,1,0, 9'd2, 16'h0);
        ed(2'b10, 8);
        step(0,1,1,1,0, 9'd2, 16'h0);
        ed(2'b00, 8);
        step(1,1,1,1,0, 9'd0, 16'h0);

        // R2: address-only refresh
        ek(4'd1, 2); er(9'd496, 2);
        step(0,1,1,1,1, 9'd496, 16'h0);
        ek(4'd2, 2);
        step(1,1,1,1,1, 9'd0, 16'h0);

        // R3: counter refresh via lower strobe, address ignored
        step(1,0,1,1,1, 9'd0, 16'h0);
        ek(4'd3, 3); er(cnt, 3); ed(2'b00, 3);
        step(0,0,1,1,0, 9'h0AA, 16'h0);
        cnt = cnt + 1'b1;
        ed(2'b00, 3);
        step(0,1,1,1,0, 9'd0, 16'h0);
        ek(4'd0, 2);
        step(1,1,1,1,1, 9'd0, 16'h0);
        // R3: via upper strobe only
        step(1,1,0,1,1, 9'd0, 16'h0);
        ek(4'd3, 3); er(cnt, 3);
        step(0,1,0,1,1, 9'h1FF, 16'h0);
        cnt = cnt + 1'b1;
        step(1,1,1,1,1, 9'd0, 16'h0);

        // R6: late write at row 6 column 1
        step(0,1,1,1,1, 9'd6, 16'h0);
        ek(4'd5, 6); ed(2'b00, 9);
        step(0,0,0,1,1, 9'd1, 16'h0);
        ek(4'd7, 6); ed(2'b00, 6);
        step(0,0,0,0,1, 9'd1, 16'h5A5A);
        step(0,1,1,1,1, 9'd1, 16'h0);
        step(1,1,1,1,1, 9'd0, 16'h0);

        // R6: read-modify-write, lower lane only at write time
        step(0,1,1,1,1, 9'd6, 16'h0);
        ek(4'd5, 4); eo(16'h5A5A, 4); ed(2'b11, 4);
        step(0,0,0,1,0, 9'd1, 16'h0);
        ed(2'b00, 9);
        step(0,0,0,1,1, 9'd1, 16'h0);
        step(0,0,1,1,1, 9'd1, 16'h0);
        ek(4'd8, 6);
        step(0,0,1,0,1, 9'd1, 16'hC3C3);
        step(0,1,1,1,1, 9'd1, 16'h0);
        step(1,1,1,1,1, 9'd0, 16'h0);
        step(0,1,1,1,1, 9'd6, 16'h0);
        ek(4'd5, 6); eo(16'h5AC3, 6); ed(2'b11, 6);
        step(0,0,0,1,0, 9'd1, 16'h0);

        // R10: hidden refresh behind the held read
        ed(2'b11, 10); eo(16'h5AC3, 10);
        step(1,0,0,1,0, 9'd0, 16'h0);
        ek(4'd4, 10); er(cnt, 10); ed(2'b11, 10); eo(16'h5AC3, 10);
        step(0,0,0,1,0, 9'h033, 16'h0);
        cnt = cnt + 1'b1;
        ed(2'b00, 8);
        step(1,1,1,1,1, 9'd0, 16'h0);

        // R11: age limit
        while (cyc < LIMIT - 40) step(1,1,1,1,1, 9'd0, 16'h0);
        es(1'b0, 11);
        step(1,1,1,1,1, 9'd0, 16'h0);
        while (cyc < LIMIT + 20) step(1,1,1,1,1, 9'd0, 16'h0);
        es(1'b1, 11);
        step(1,1,1,1,1, 9'd0, 16'h0);

        // R3: sweep every row through the counter, including the 511 -> 0 wrap
        for (int i = 0; i < 512; i++) begin
            step(1,0,1,1,1, 9'd0, 16'h0);
            ek(4'd3, 3); er(cnt, 3);
            step(0,0,1,1,1, 9'(i), 16'h0);
            cnt = cnt + 1'b1;
            step(1,1,1,1,1, 9'd0, 16'h0);
        end
        step(1,1,1,1,1, 9'd0, 16'h0);
        step(1,1,1,1,1, 9'd0, 16'h0);
        es(1'b0, 11);
        step(1,1,1,1,1, 9'd0, 16'h0);

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule